// File: doc/BRIEF.md
# CAN Receive Identifier Acceptance Filter

This block decides which receive message buffer, if any, takes an incoming CAN frame identifier. It stores a table of buffer entries. Each entry holds a 29-bit identifier, a flag that says whether the entry expects an extended frame, and a flag that marks it as in use. When the frame layer has a new identifier, it pulses `start` together with the identifier and the frame's extended flag. The filter then walks the table one entry per clock, starting at entry 0, and stops at the first entry that accepts the frame. It reports the result with a one-cycle `done` pulse, a hit flag and the entry index.

Each comparison runs through an acceptance mask. A mask bit of 1 means the frame bit must equal the stored bit, and a mask bit of 0 means the bit is not compared. In shared-mask mode one general mask covers the table, except that entries 14 and 15 each use a dedicated mask of their own. In individual-mask mode every entry uses its own stored mask, and the shared masks play no part. For a standard frame only the 11 base identifier bits (28 down to 18) are compared. An entry whose format flag differs from the frame's never accepts it. Table entries and masks are loaded through a write port that only acts while no walk is in progress.

Top module: `can_acc_filter`

## Requirements
- R1: A mask bit of 1 requires the frame identifier bit to equal the stored bit; a mask bit of 0 excludes that bit from the comparison.
- R2: With `indiv_mode` low, entry 14 uses the first dedicated mask and entry 15 uses the second dedicated mask. Every other entry uses the general mask.
- R3: For a standard frame (`frame_ide`=0) only identifier bits 28..18 are compared, and bits 17..0 have no effect. For an extended frame all 29 bits are compared.
- R4: An entry whose stored format flag differs from `frame_ide` never accepts the frame.
- R5: With `indiv_mode` high, each entry is compared under its own per-entry mask. The general and dedicated masks then have no effect.
- R6: A `start` pulse while idle begins a walk from entry 0. When entry k is the lowest-numbered entry that accepts the frame, `done` pulses for one cycle k+1 clocks after the start edge, with `hit`=1 and `hit_index`=k.
- R7: Entries whose in-use flag is 0 are skipped. If no entry accepts the frame, `done` pulses 64 clocks after the start edge with `hit`=0 and `hit_index`=0.
- R8: While `busy` is high, write-port cycles are dropped and leave the table and masks unchanged, and a further `start` is ignored.
- R9: After reset `busy`, `done`, `hit` and `hit_index` are 0, every entry is out of use, and every mask is all ones.
- R10: Write address `wr_addr[7:6]` selects the space and `wr_addr[5:0]` the entry. In space 0, `wr_data[28:0]` is the identifier, bit 29 the format flag (1 = extended) and bit 30 the in-use flag. In space 1, `wr_data[28:0]` is the entry's individual mask. In space 2, entry 0 is the general mask, entry 1 the mask for entry 14, and entry 2 the mask for entry 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the table and masks |
| wr_addr | input | 8 | Write address: space in bits 7..6, entry in bits 5..0 |
| wr_data | input | 31 | Write data |
| indiv_mode | input | 1 | 1 selects per-entry masks, 0 selects shared masks |
| start | input | 1 | One-cycle request to filter the presented frame |
| frame_id | input | 29 | Incoming identifier, base field in bits 28..18 |
| frame_ide | input | 1 | Incoming frame format, 1 = extended |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when the walk ends |
| hit | output | 1 | An entry accepted the frame |
| hit_index | output | 6 | Index of the accepting entry |

## Verification
The hardest case to reach from the ports is a frame that one entry turns away under the general mask while entry 14 accepts it, because its dedicated mask ignores the single bit that differs. The bench loads entry 3 and entry 14 with the same extended identifier and gives entry 14 a mask with bit 28 cleared. It then offers a frame that differs only in bit 28. Switching `indiv_mode` on the same frame must turn that hit into a miss. A second hard case is a write or a second start that lands mid-walk. The bench issues both during a 64-cycle miss walk, then rescans to show that neither had any effect.

// File: rtl/can_flt_pkg.sv
package can_flt_pkg;

   localparam int unsigned ID_W   = 29;
   localparam int unsigned BASE_W = 11;
   localparam int unsigned DATA_W = ID_W + 2;

   typedef logic [ID_W-1:0] can_id_t;

   typedef enum logic [1:0] {
      SPC_ENTRY  = 2'd0,
      SPC_IMASK  = 2'd1,
      SPC_SHARED = 2'd2,
      SPC_NONE   = 2'd3
   } wr_space_e;

   function automatic can_id_t base_field_only();
      can_id_t m;
      m = '0;
      for (int b = ID_W - BASE_W; b < ID_W; b++) m[b] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/can_flt_store.sv
module can_flt_store
   import can_flt_pkg::*;
#(
   parameter int unsigned NUM_BUF  = 64,
   parameter bit          INDIV_EN = 1'b1,
   localparam int unsigned IDX_W   = $clog2(NUM_BUF)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_go,
   input  wr_space_e           wr_space,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [IDX_W-1:0]    rd_idx,
   output can_id_t             rd_id,
   output logic                rd_ide,
   output logic                rd_act,
   output can_id_t             rd_imask,
   output can_id_t             gmask,
   output can_id_t             dmask_a,
   output can_id_t             dmask_b
);

   can_id_t            id_q [NUM_BUF];
   logic [NUM_BUF-1:0] ide_q;
   logic [NUM_BUF-1:0] act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_BUF; i++) id_q[i] <= '0;
         ide_q <= '0;
         act_q <= '0;
      end else if (wr_go && wr_space == SPC_ENTRY) begin
         id_q[wr_idx]  <= wr_data[ID_W-1:0];
         ide_q[wr_idx] <= wr_data[ID_W];
         act_q[wr_idx] <= wr_data[ID_W+1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gmask   <= '1;
         dmask_a <= '1;
         dmask_b <= '1;
      end else if (wr_go && wr_space == SPC_SHARED) begin
         case (wr_idx)
            IDX_W'(0): gmask   <= wr_data[ID_W-1:0];
            IDX_W'(1): dmask_a <= wr_data[ID_W-1:0];
            IDX_W'(2): dmask_b <= wr_data[ID_W-1:0];
            default:   ;
         endcase
      end
   end

   assign rd_id  = id_q[rd_idx];
   assign rd_ide = ide_q[rd_idx];
   assign rd_act = act_q[rd_idx];

   generate
      if (INDIV_EN) begin : g_imask
         can_id_t im_q [NUM_BUF];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < NUM_BUF; i++) im_q[i] <= '1;
            end else if (wr_go && wr_space == SPC_IMASK) begin
               im_q[wr_idx] <= wr_data[ID_W-1:0];
            end
         end
         assign rd_imask = im_q[rd_idx];
      end else begin : g_no_imask
         assign rd_imask = '1;
      end
   endgenerate

endmodule

// File: rtl/can_flt_mask_sel.sv
module can_flt_mask_sel
   import can_flt_pkg::*;
#(
   parameter int unsigned NUM_BUF   = 64,
   parameter int unsigned DED_A_IDX = 14,
   parameter int unsigned DED_B_IDX = 15,
   parameter bit          INDIV_EN  = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_BUF)
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             indiv_mode,
   input  can_id_t          gmask,
   input  can_id_t          dmask_a,
   input  can_id_t          dmask_b,
   input  can_id_t          imask,
   output can_id_t          mask
);

   can_id_t shared_mask;

   always_comb begin
      if (idx == IDX_W'(DED_A_IDX))      shared_mask = dmask_a;
      else if (idx == IDX_W'(DED_B_IDX)) shared_mask = dmask_b;
      else                               shared_mask = gmask;
   end

   generate
      if (INDIV_EN) begin : g_sel_indiv
         assign mask = indiv_mode ? imask : shared_mask;
      end else begin : g_sel_shared
         logic unused_mode;
         assign unused_mode = indiv_mode ^ (^imask);
         assign mask = shared_mask;
      end
   endgenerate

endmodule

// File: rtl/can_flt_cmp.sv
module can_flt_cmp
   import can_flt_pkg::*;
(
   input  can_id_t frame_id,
   input  logic    frame_ide,
   input  can_id_t buf_id,
   input  logic    buf_ide,
   input  logic    buf_act,
   input  can_id_t mask,
   output logic    match
);

   can_id_t span;
   can_id_t diff;

   assign span  = frame_ide ? '1 : base_field_only();
   assign diff  = (frame_id ^ buf_id) & mask & span;
   assign match = buf_act && (buf_ide == frame_ide) && (diff == '0);

endmodule

// File: rtl/can_flt_scan.sv
module can_flt_scan #(
   parameter int unsigned NUM_BUF = 64,
   localparam int unsigned IDX_W  = $clog2(NUM_BUF),
   localparam int unsigned LAST   = NUM_BUF - 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             cmp_hit,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic             done,
   output logic             hit,
   output logic [IDX_W-1:0] hit_index
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         idx       <= '0;
         done      <= 1'b0;
         hit       <= 1'b0;
         hit_index <= '0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy <= 1'b1;
               idx  <= '0;
               hit  <= 1'b0;
            end
         end else if (cmp_hit) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            hit       <= 1'b1;
            hit_index <= idx;
         end else if (idx == IDX_W'(LAST)) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            hit       <= 1'b0;
            hit_index <= '0;
         end else begin
            idx <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/can_acc_filter.sv
module can_acc_filter
   import can_flt_pkg::*;
#(
   parameter int unsigned NUM_BUF   = 64,
   parameter int unsigned DED_A_IDX = 14,
   parameter int unsigned DED_B_IDX = 15,
   parameter bit          INDIV_EN  = 1'b1,
   localparam int unsigned IDX_W    = $clog2(NUM_BUF),
   localparam int unsigned ADDR_W   = IDX_W + 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [can_flt_pkg::DATA_W-1:0] wr_data,
   input  logic                          indiv_mode,
   input  logic                          start,
   input  logic [can_flt_pkg::ID_W-1:0]  frame_id,
   input  logic                          frame_ide,
   output logic                          busy,
   output logic                          done,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_index
);

   generate
      if ((1 << IDX_W) != NUM_BUF || NUM_BUF < 4) begin : g_bad_depth
         $error("can_acc_filter: NUM_BUF must be a power of two of at least 4");
      end
      if (DED_A_IDX >= NUM_BUF || DED_B_IDX >= NUM_BUF || DED_A_IDX == DED_B_IDX) begin : g_bad_ded
         $error("can_acc_filter: dedicated mask indices out of range or equal");
      end
   endgenerate

   logic             scan_busy;
   logic [IDX_W-1:0] scan_idx;
   logic             cmp_hit;
   logic             wr_go;
   can_id_t          fr_id_q;
   logic             fr_ide_q;
   logic             mode_q;
   can_id_t          rd_id, rd_imask, gmask, dmask_a, dmask_b, sel_mask;
   logic             rd_ide, rd_act;

   assign wr_go = wr_en && !scan_busy;
   assign busy  = scan_busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fr_id_q  <= '0;
         fr_ide_q <= 1'b0;
         mode_q   <= 1'b0;
      end else if (start && !scan_busy) begin
         fr_id_q  <= frame_id;
         fr_ide_q <= frame_ide;
         mode_q   <= indiv_mode;
      end
   end

   can_flt_store #(.NUM_BUF(NUM_BUF), .INDIV_EN(INDIV_EN)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_go    (wr_go),
      .wr_space (wr_space_e'(wr_addr[ADDR_W-1 -: 2])),
      .wr_idx   (wr_addr[IDX_W-1:0]),
      .wr_data  (wr_data),
      .rd_idx   (scan_idx),
      .rd_id    (rd_id),
      .rd_ide   (rd_ide),
      .rd_act   (rd_act),
      .rd_imask (rd_imask),
      .gmask    (gmask),
      .dmask_a  (dmask_a),
      .dmask_b  (dmask_b)
   );

   can_flt_mask_sel #(
      .NUM_BUF(NUM_BUF), .DED_A_IDX(DED_A_IDX),
      .DED_B_IDX(DED_B_IDX), .INDIV_EN(INDIV_EN)
   ) u_msel (
      .idx        (scan_idx),
      .indiv_mode (mode_q),
      .gmask      (gmask),
      .dmask_a    (dmask_a),
      .dmask_b    (dmask_b),
      .imask      (rd_imask),
      .mask       (sel_mask)
   );

   can_flt_cmp u_cmp (
      .frame_id  (fr_id_q),
      .frame_ide (fr_ide_q),
      .buf_id    (rd_id),
      .buf_ide   (rd_ide),
      .buf_act   (rd_act),
      .mask      (sel_mask),
      .match     (cmp_hit)
   );

   can_flt_scan #(.NUM_BUF(NUM_BUF)) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .cmp_hit   (cmp_hit),
      .busy      (scan_busy),
      .idx       (scan_idx),
      .done      (done),
      .hit       (hit),
      .hit_index (hit_index)
   );

endmodule

// File: rtl/can_acc_filter_chk.sv
module can_acc_filter_chk #(
   parameter int unsigned NUM_BUF = 64,
   localparam int unsigned IDX_W  = $clog2(NUM_BUF),
   localparam int unsigned LAST   = NUM_BUF - 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             done,
   input logic             hit,
   input logic [IDX_W-1:0] hit_index,
   input logic             scan_busy,
   input logic [IDX_W-1:0] scan_idx,
   input logic             cmp_hit
);

   // R6: done lasts one cycle
   p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R6: done only ends a walk that was in progress
   p_done_after_walk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(scan_busy));

   // R6: the walk advances by one entry per clock
   p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_busy && $past(scan_busy)) |-> scan_idx == IDX_W'($past(scan_idx) + 1'b1));

   // R6: a reported hit is the entry the comparator accepted
   p_hit_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hit) |-> ($past(cmp_hit) && hit_index == $past(scan_idx)));

   // R7: a miss is reported only after the last entry
   p_miss_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !hit) |-> ($past(scan_idx) == IDX_W'(LAST) && !$past(cmp_hit)));

endmodule

bind can_acc_filter can_acc_filter_chk #(.NUM_BUF(NUM_BUF)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .done      (done),
   .hit       (hit),
   .hit_index (hit_index),
   .scan_busy (scan_busy),
   .scan_idx  (scan_idx),
   .cmp_hit   (cmp_hit)
);

// File: tb/can_acc_filter_test.sv
`timescale 1ns/1ps
module can_acc_filter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [30:0] wr_data = '0;
   logic        indiv_mode = 1'b0;
   logic        start = 1'b0;
   logic [28:0] frame_id = '0;
   logic        frame_ide = 1'b0;
   logic        busy, done, hit;
   logic [5:0]  hit_index;

   int errors = 0;
   int checks = 0;

   always #2.5 clk = ~clk;

   can_acc_filter uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .indiv_mode(indiv_mode), .start(start),
      .frame_id(frame_id), .frame_ide(frame_ide), .busy(busy),
      .done(done), .hit(hit), .hit_index(hit_index)
   );

   // vector: {indiv, ide, id[28:0], exp_hit, exp_idx[5:0]}
   localparam int NV = 11;
   localparam logic [37:0] VEC [NV] = '{
      {1'b0, 1'b0, 29'h0403FFFF, 1'b1, 6'd2},   // R3 low bits ignored
      {1'b0, 1'b1, 29'h00ABCDEF, 1'b1, 6'd3},   // R3 extended exact
      {1'b0, 1'b1, 29'h10ABCDEF, 1'b1, 6'd14},  // R2 dedicated A
      {1'b0, 1'b0, 29'h0C280000, 1'b1, 6'd15},  // R2 dedicated B
      {1'b0, 1'b1, 29'h04000000, 1'b0, 6'd0},   // R4 ext vs std entry
      {1'b0, 1'b0, 29'h00A80000, 1'b0, 6'd0},   // R4 std vs ext entry
      {1'b0, 1'b0, 29'h083C0000, 1'b0, 6'd0},   // R1 general mask all ones
      {1'b1, 1'b0, 29'h083C0000, 1'b1, 6'd5},   // R5 own mask
      {1'b1, 1'b1, 29'h10ABCDEF, 1'b0, 6'd0},   // R5 dedicated no effect
      {1'b1, 1'b0, 29'h0C280000, 1'b0, 6'd0},   // R5 dedicated no effect
      {1'b0, 1'b0, 29'h048C0000, 1'b1, 6'd20}   // R2 general mask
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] spc, input int idx, input logic [30:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = {spc, 6'(idx)}; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wr_entry(input int idx, input logic [28:0] id, input bit ide, input bit act);
      wr(2'd0, idx, {act, ide, id});
   endtask

   task automatic scan(input bit ide, input logic [28:0] id, input bit ind,
                       output bit h, output int ix, output int cyc);
      @(negedge clk);
      start = 1'b1; frame_id = id; frame_ide = ide; indiv_mode = ind;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      h = 1'b0; ix = -1;
      for (int n = 0; n < 200; n++) begin
         @(posedge clk);
         @(negedge clk);
         cyc++;
         if (done) begin
            h = hit; ix = int'(hit_index);
            break;
         end
      end
   endtask

   initial begin : watchdog
      #100000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      bit h;
      int ix, cyc;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(busy == 0 && done == 0 && hit == 0 && hit_index == 0, "R9 reset outputs",
            int'({busy, done, hit}), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // R9: all entries out of use, mask all ones -> any frame misses
      scan(1'b0, 29'h0, 1'b0, h, ix, cyc);
      check(h == 0 && cyc == 64, "R9 empty table misses", cyc, 64);

      // R10 load table
      wr_entry(2, 29'h04000000, 1'b0, 1'b1);
      wr_entry(3, 29'h00ABCDEF, 1'b1, 1'b1);
      wr_entry(5, 29'h08000000, 1'b0, 1'b1);
      wr_entry(14, 29'h00ABCDEF, 1'b1, 1'b1);
      wr_entry(15, 29'h0C000000, 1'b0, 1'b1);
      wr_entry(20, 29'h048C0000, 1'b0, 1'b1);
      wr(2'd2, 0, {2'b00, 29'h1FFFFFFF});
      wr(2'd2, 1, {2'b00, 29'h0FFFFFFF});
      wr(2'd2, 2, {2'b00, 29'h1FC00000});
      wr(2'd1, 5, {2'b00, 29'h1FC00000});

      for (int v = 0; v < NV; v++) begin
         logic [37:0] e;
         e = VEC[v];
         scan(e[36], e[35:7], e[37], h, ix, cyc);
         check(h == e[6] && (!e[6] || ix == int'(e[5:0])),
               $sformatf("R1-table vec%0d hit/index (R2 R3 R4 R5)", v),
               h ? ix : -1, e[6] ? int'(e[5:0]) : -1);
      end

      // R1: relax general mask to base bits 28..22 only
      wr(2'd2, 0, {2'b00, 29'h1FC00000});
      scan(1'b0, 29'h043C0000, 1'b0, h, ix, cyc);
      check(h && ix == 2, "R1 cleared mask bits ignored", ix, 2);
      scan(1'b0, 29'h143C0000, 1'b0, h, ix, cyc);
      check(!h, "R1 set mask bit compared", int'(h), 0);

      // R6 lowest index wins, latency k+1
      wr_entry(40, 29'h04000000, 1'b0, 1'b1);
      scan(1'b0, 29'h04000000, 1'b0, h, ix, cyc);
      check(h && ix == 2, "R6 lowest index wins", ix, 2);
      check(cyc == 3, "R6 latency for entry 2", cyc, 3);
      // R7 inactive entry skipped
      wr_entry(2, 29'h04000000, 1'b0, 1'b0);
      scan(1'b0, 29'h04000000, 1'b0, h, ix, cyc);
      check(h && ix == 40, "R7 inactive entry skipped", ix, 40);
      check(cyc == 41, "R6 latency for entry 40", cyc, 41);
      // R7 miss after full walk
      scan(1'b1, 29'h1F0F0F0F, 1'b0, h, ix, cyc);
      check(!h && ix == 0 && cyc == 64, "R7 miss latency", cyc, 64);

      // R8 write and start during a walk are ignored
      @(negedge clk);
      start = 1'b1; frame_id = 29'h1F0F0F0F; frame_ide = 1'b1; indiv_mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
      check(busy == 1, "R8 busy during walk", int'(busy), 1);
      wr_entry(1, 29'h1F0F0F0F, 1'b1, 1'b1);
      @(negedge clk);
      start = 1'b1; frame_id = 29'h048C0000; frame_ide = 1'b0;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      for (int n = 0; n < 200; n++) begin
         if (done) break;
         @(negedge clk);
         cyc++;
      end
      check(done && !hit, "R8 second start ignored", int'(hit), 0);
      @(negedge clk);
      check(!busy && !done, "R8 no second walk", int'({busy, done}), 0);
      scan(1'b1, 29'h1F0F0F0F, 1'b0, h, ix, cyc);
      check(!h, "R8 busy write dropped", h ? ix : -1, -1);
      wr_entry(1, 29'h1F0F0F0F, 1'b1, 1'b1);
      scan(1'b1, 29'h1F0F0F0F, 1'b0, h, ix, cyc);
      check(h && ix == 1, "R10 idle write stored", ix, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule